// File: doc/BRIEF.md
# Character-Row Screen Address Generator

This block produces the display-memory byte address for a frame whose bytes are arranged as character cells eight scan lines tall. Across a scan line, successive bytes lie eight apart; each new scan line inside a character row begins one byte after the previous one. After the eighth line the address drops back by seven, which lands on the first byte of the next character row. All addresses stay inside a screen region that ends at the top of a 32 KiB window, and any address that runs past the top folds back by the size of that region.

Modes with 25 character rows do not fill the 256 visible lines. For these modes the block inserts blank gap lines between rows and a long blank margin after the last row. While a gap is running the address is frozen and the `row_gap` flag is high, so the fetch logic can blank its output.

The surrounding timing logic drives three strobes: one at the start of each frame, one at the end of each scan line and one for each byte fetched. It reads `scr_addr` and `row_gap` on the cycle after each strobe. Memory access itself happens outside this block.

Top module: `chrow_addr_gen`

## Requirements
- R1: After reset, `scr_addr` is 0x6000 (the start address of mode code 6) and `row_gap` is 0.
- R2: When `frame_go` is high, the mode code on `mode_sel` is captured. `scr_addr` and the saved line start are both loaded with that mode's start address, computed as (0x8000 − columns×8×rows) rounded down to a multiple of 256. For codes 0..6 the starts are 0x3000, 0x5800, 0x6C00, 0x4100, 0x5800, 0x5800 and 0x6000. Code 7 behaves as code 6. A change on `mode_sel` without `frame_go` has no effect on the running frame.
- R3: A `col_go` pulse adds 8 to `scr_addr`. The pulse is ignored when `frame_go` or `line_go` is high in the same cycle. Priority is frame, then line, then column.
- R4: Whenever a result would reach 0x8000 or more, the region size (0x8000 minus the captured start) is subtracted from it.
- R5: Each `line_go` pulse advances a scan-line count that `frame_go` clears. Only pulses that bring the count strictly between 28 and 284 are processed. On a processed line that does not end a character row, `scr_addr` becomes the saved line start plus 1 (with the wrap of R4), and this value becomes the new line start.
- R6: On a processed line that ends a character row (every 8th counted line), `scr_addr` drops by 7 and becomes the new line start. A gap counter is then loaded with 256/rows − 8: that is 2 for 25-row modes (codes 3, 6, 7) and 0 for 32-row modes. While the counter is nonzero, `row_gap` is 1, processed lines only decrement the counter, and `col_go` is ignored.
- R7: In a 25-row mode, when the counted line total reaches rows×8 = 200, the gap counter is loaded with the margin 312 − 25×10 + 2 = 64 instead of 2. This keeps `row_gap` high for the rest of the visible area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Mode code, captured on `frame_go` |
| frame_go | input | 1 | Start-of-frame strobe |
| line_go | input | 1 | End-of-scan-line strobe |
| col_go | input | 1 | Byte-advance strobe |
| scr_addr | output | 16 | Current display byte address |
| row_gap | output | 1 | High while blank gap or margin lines run |

## Verification
The bench targets the following corner cases:

- **Row turnover.** A design that updated the line start only at row ends would repeat the same line seven times. One that subtracted the wrong amount would drift by one column per row.
- **Gaps and margin in 25-row modes.** A design that advanced the address during gaps, or honoured `col_go` in them, would shift every later row. One that missed the margin load would show rows below line 200.
- **Fold-back at the region top.** A long run of `col_go` pushes the address past 0x8000; a missing wrap would leave the region.
- **Simultaneous strobes.** A design that applied a column step on a frame or line cycle would be off by eight.

// File: rtl/chrow_addr_pkg.sv
package chrow_addr_pkg;

   typedef enum logic [2:0] {
      WOP_HOLD,
      WOP_STEP,
      WOP_LINE,
      WOP_ROW,
      WOP_FRAME
   } walk_op_e;

   function automatic int mode_cols(int m);
      case (m)
         0, 3:    return 80;
         2:       return 20;
         default: return 40;
      endcase
   endfunction

   function automatic int mode_rows(int m);
      if (m == 3 || m >= 6) return 25;
      return 32;
   endfunction

   function automatic int mode_start(int m, int top, int lpr, int align);
      return (top - mode_cols(m) * lpr * mode_rows(m)) & ~(align - 1);
   endfunction

endpackage

// File: rtl/chrow_mode_cfg.sv
module chrow_mode_cfg
   import chrow_addr_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int MODE_W        = 3,
   parameter int LCNT_W        = 9,
   parameter int SCREEN_TOP    = 32'h8000,
   parameter int START_ALIGN   = 256,
   parameter int LINES_PER_ROW = 8,
   parameter int VIS_LINES     = 256,
   parameter int FRAME_LINES   = 312
) (
   input  logic [MODE_W-1:0] mode_idx,
   output logic [ADDR_W-1:0] start,
   output logic [ADDR_W-1:0] region,
   output logic [LCNT_W-1:0] gap_lines,
   output logic [LCNT_W-1:0] footer,
   output logic [LCNT_W-1:0] margin,
   output logic              has_gap
);
   localparam int NUM_MODES = 2 ** MODE_W;

   logic [ADDR_W-1:0] start_tbl  [NUM_MODES];
   logic [ADDR_W-1:0] region_tbl [NUM_MODES];
   logic [LCNT_W-1:0] gap_tbl    [NUM_MODES];
   logic [LCNT_W-1:0] foot_tbl   [NUM_MODES];
   logic [LCNT_W-1:0] marg_tbl   [NUM_MODES];

   for (genvar gi = 0; gi < NUM_MODES; gi++) begin : g_mode
      localparam int ROWS  = mode_rows(gi);
      localparam int SIZE  = mode_cols(gi) * LINES_PER_ROW * ROWS;
      localparam int START = mode_start(gi, SCREEN_TOP, LINES_PER_ROW, START_ALIGN);
      localparam int GAP   = VIS_LINES / ROWS - LINES_PER_ROW;
      localparam int FOOT  = ROWS * LINES_PER_ROW;
      localparam int MARG  = FRAME_LINES - ROWS * (LINES_PER_ROW + GAP) + GAP;

      if (SIZE > SCREEN_TOP) begin : g_bad_size
         $error("mode screen larger than window");
      end
      if (GAP < 0) begin : g_bad_gap
         $error("mode rows exceed visible lines");
      end
      if (MARG >= 2 ** LCNT_W) begin : g_bad_marg
         $error("line counter too narrow for margin");
      end

      assign start_tbl[gi]  = ADDR_W'(START);
      assign region_tbl[gi] = ADDR_W'(SCREEN_TOP - START);
      assign gap_tbl[gi]    = LCNT_W'(GAP);
      assign foot_tbl[gi]   = LCNT_W'(FOOT);
      assign marg_tbl[gi]   = LCNT_W'(MARG);
   end

   assign start     = start_tbl[mode_idx];
   assign region    = region_tbl[mode_idx];
   assign gap_lines = gap_tbl[mode_idx];
   assign footer    = foot_tbl[mode_idx];
   assign margin    = marg_tbl[mode_idx];
   assign has_gap   = (gap_tbl[mode_idx] != '0);

endmodule

// File: rtl/chrow_line_seq.sv
module chrow_line_seq #(
   parameter int LCNT_W        = 9,
   parameter int LINES_PER_ROW = 8,
   parameter int VIS_FIRST     = 28,
   parameter int VIS_LINES     = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_go,
   input  logic              line_go,
   input  logic [LCNT_W-1:0] gap_lines,
   input  logic [LCNT_W-1:0] footer,
   input  logic [LCNT_W-1:0] margin,
   input  logic              has_gap,
   output logic              adv_line,
   output logic              adv_row,
   output logic              gap_active
);
   localparam logic [LCNT_W-1:0] Y_MAX    = '1;
   localparam logic [LCNT_W-1:0] WIN_LO   = LCNT_W'(VIS_FIRST);
   localparam logic [LCNT_W-1:0] WIN_HI   = LCNT_W'(VIS_FIRST + VIS_LINES);
   localparam logic [LCNT_W-1:0] ROW_MASK = LCNT_W'(LINES_PER_ROW - 1);

   if ((LINES_PER_ROW & (LINES_PER_ROW - 1)) != 0) begin : g_bad_lpr
      $error("lines per row must be a power of two");
   end
   if (VIS_FIRST + VIS_LINES >= 2 ** LCNT_W) begin : g_bad_win
      $error("line counter too narrow for window");
   end

   logic [LCNT_W-1:0] y_q, ln_q, gap_q;
   logic [LCNT_W-1:0] y_nx, ln_nx;
   logic              in_win, gap_busy, row_end, take;

   always_comb begin
      y_nx     = (y_q == Y_MAX) ? y_q : y_q + 1'b1;
      in_win   = (y_nx > WIN_LO) && (y_nx < WIN_HI);
      gap_busy = (gap_q != '0);
      ln_nx    = ln_q + 1'b1;
      row_end  = ((ln_nx & ROW_MASK) == '0);
      take     = line_go && !frame_go && in_win && !gap_busy;
      adv_line = take && !row_end;
      adv_row  = take && row_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q   <= '0;
         ln_q  <= '0;
         gap_q <= '0;
      end else if (frame_go) begin
         y_q   <= '0;
         ln_q  <= '0;
         gap_q <= '0;
      end else if (line_go) begin
         y_q <= y_nx;
         if (in_win) begin
            if (gap_busy) begin
               gap_q <= gap_q - 1'b1;
            end else begin
               ln_q <= ln_nx;
               if (row_end) begin
                  gap_q <= (has_gap && ln_nx == footer) ? margin : gap_lines;
               end
            end
         end
      end
   end

   assign gap_active = gap_busy;

   AST_GAP_NO_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      gap_active |-> !(adv_line || adv_row)); // R6

endmodule

// File: rtl/chrow_addr_walk.sv
module chrow_addr_walk
   import chrow_addr_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int SCREEN_TOP    = 32'h8000,
   parameter int LINES_PER_ROW = 8,
   parameter int RST_START     = 32'h6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  walk_op_e          op,
   input  logic [ADDR_W-1:0] start,
   input  logic [ADDR_W-1:0] region,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W:0] TOP_X   = (ADDR_W + 1)'(SCREEN_TOP);
   localparam logic [ADDR_W:0] STRIDE  = (ADDR_W + 1)'(LINES_PER_ROW);
   localparam logic [ADDR_W:0] BACKOFF = (ADDR_W + 1)'(LINES_PER_ROW - 1);

   if (SCREEN_TOP > 2 ** ADDR_W) begin : g_bad_top
      $error("screen top outside address range");
   end

   logic [ADDR_W-1:0] addr_q, lstart_q;

   function automatic logic [ADDR_W-1:0] fold(input logic [ADDR_W:0] v,
                                              input logic [ADDR_W-1:0] reg_sz);
      logic [ADDR_W:0] r;
      r = (v >= TOP_X) ? v - {1'b0, reg_sz} : v;
      return r[ADDR_W-1:0];
   endfunction

   logic [ADDR_W-1:0] nxt_step, nxt_line, nxt_row;

   always_comb begin
      nxt_step = fold({1'b0, addr_q} + STRIDE, region);
      nxt_line = fold({1'b0, lstart_q} + 1'b1, region);
      nxt_row  = fold({1'b0, addr_q} - BACKOFF, region);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= ADDR_W'(RST_START);
         lstart_q <= ADDR_W'(RST_START);
      end else begin
         case (op)
            WOP_FRAME: begin
               addr_q   <= start;
               lstart_q <= start;
            end
            WOP_STEP: addr_q <= nxt_step;
            WOP_LINE: begin
               addr_q   <= nxt_line;
               lstart_q <= nxt_line;
            end
            WOP_ROW: begin
               addr_q   <= nxt_row;
               lstart_q <= nxt_row;
            end
            default: ;
         endcase
      end
   end

   assign addr = addr_q;

   AST_ADDR_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, addr_q} < TOP_X); // R4

endmodule

// File: rtl/chrow_addr_gen.sv
module chrow_addr_gen
   import chrow_addr_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int MODE_W        = 3,
   parameter int SCREEN_TOP    = 32'h8000,
   parameter int START_ALIGN   = 256,
   parameter int LINES_PER_ROW = 8,
   parameter int VIS_FIRST     = 28,
   parameter int VIS_LINES     = 256,
   parameter int FRAME_LINES   = 312,
   parameter int MODE_RST      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              frame_go,
   input  logic              line_go,
   input  logic              col_go,
   output logic [ADDR_W-1:0] scr_addr,
   output logic              row_gap
);
   localparam int LCNT_W    = $clog2(FRAME_LINES + 1);
   localparam int RST_START = mode_start(MODE_RST, SCREEN_TOP, LINES_PER_ROW, START_ALIGN);
   localparam logic [ADDR_W-1:0] STRIDE_A  = ADDR_W'(LINES_PER_ROW);
   localparam logic [ADDR_W-1:0] ALIGN_M   = ADDR_W'(START_ALIGN - 1);
   localparam logic [ADDR_W-1:0] ROW_BITS  = ADDR_W'(LINES_PER_ROW - 1);

   if (MODE_RST >= 2 ** MODE_W) begin : g_bad_rst
      $error("reset mode outside mode range");
   end
   if ((START_ALIGN & (START_ALIGN - 1)) != 0) begin : g_bad_align
      $error("start alignment must be a power of two");
   end

   logic [MODE_W-1:0] mode_q, mode_eff;
   logic [ADDR_W-1:0] cfg_start, cfg_region;
   logic [LCNT_W-1:0] cfg_gap, cfg_foot, cfg_marg;
   logic              cfg_has_gap;
   logic              adv_line, adv_row, gap_active;
   walk_op_e          op;

   always_ff @(posedge clk) begin
      if (!rst_n)        mode_q <= MODE_W'(MODE_RST);
      else if (frame_go) mode_q <= mode_sel;
   end

   assign mode_eff = frame_go ? mode_sel : mode_q;

   chrow_mode_cfg #(
      .ADDR_W       (ADDR_W),
      .MODE_W       (MODE_W),
      .LCNT_W       (LCNT_W),
      .SCREEN_TOP   (SCREEN_TOP),
      .START_ALIGN  (START_ALIGN),
      .LINES_PER_ROW(LINES_PER_ROW),
      .VIS_LINES    (VIS_LINES),
      .FRAME_LINES  (FRAME_LINES)
   ) u_cfg (
      .mode_idx (mode_eff),
      .start    (cfg_start),
      .region   (cfg_region),
      .gap_lines(cfg_gap),
      .footer   (cfg_foot),
      .margin   (cfg_marg),
      .has_gap  (cfg_has_gap)
   );

   chrow_line_seq #(
      .LCNT_W       (LCNT_W),
      .LINES_PER_ROW(LINES_PER_ROW),
      .VIS_FIRST    (VIS_FIRST),
      .VIS_LINES    (VIS_LINES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_go  (frame_go),
      .line_go   (line_go),
      .gap_lines (cfg_gap),
      .footer    (cfg_foot),
      .margin    (cfg_marg),
      .has_gap   (cfg_has_gap),
      .adv_line  (adv_line),
      .adv_row   (adv_row),
      .gap_active(gap_active)
   );

   always_comb begin
      if (frame_go)                              op = WOP_FRAME;
      else if (adv_row)                          op = WOP_ROW;
      else if (adv_line)                         op = WOP_LINE;
      else if (col_go && !line_go && !gap_active) op = WOP_STEP;
      else                                       op = WOP_HOLD;
   end

   chrow_addr_walk #(
      .ADDR_W       (ADDR_W),
      .SCREEN_TOP   (SCREEN_TOP),
      .LINES_PER_ROW(LINES_PER_ROW),
      .RST_START    (RST_START)
   ) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .start (cfg_start),
      .region(cfg_region),
      .addr  (scr_addr)
   );

   assign row_gap = gap_active;

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(op == WOP_STEP)) |->
         (scr_addr == $past(scr_addr) + STRIDE_A) ||
         (scr_addr == $past(scr_addr) + STRIDE_A - $past(cfg_region))); // R3

   AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |=> ((scr_addr & ALIGN_M) == '0) && !row_gap); // R2

   AST_GAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (row_gap && !frame_go) |=> $stable(scr_addr)); // R6

   AST_LINE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(op == WOP_LINE)) |-> ((scr_addr & ROW_BITS) != '0)); // R5

endmodule

// File: tb/chrow_addr_gen_tb.sv
`timescale 1ns/1ps
module chrow_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic        frame_go = 1'b0, line_go = 1'b0, col_go = 1'b0;
   logic [15:0] scr_addr;
   logic        row_gap;

   always #2 clk = ~clk;

   chrow_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .frame_go(frame_go),
      .line_go(line_go), .col_go(col_go), .scr_addr(scr_addr), .row_gap(row_gap)
   );

   int    checks = 0, fails = 0;
   bit    done = 0;
   int    exp_addr_q[$];
   bit    exp_gap_q[$];
   string exp_tag_q[$];

   int m_mode = 6, m_addr = 'h6000, m_ls = 'h6000, m_y = 0, m_ln = 0, m_gap = 0;

   function automatic int f_cols(int m);
      if (m == 0 || m == 3) return 80;
      if (m == 2) return 20;
      return 40;
   endfunction
   function automatic int f_rows(int m);
      return (m == 3 || m >= 6) ? 25 : 32;
   endfunction
   function automatic int f_start(int m);
      return ('h8000 - f_cols(m) * 8 * f_rows(m)) & 'hFF00;
   endfunction
   function automatic int f_wrap(int v);
      if (v >= 'h8000) return v - ('h8000 - f_start(m_mode));
      return v;
   endfunction

   task automatic strobe(bit f, bit l, bit c, int msel);
      string tag;
      @(negedge clk);
      frame_go = f; line_go = l; col_go = c; mode_sel = 3'(msel);
      if (f) begin
         m_mode = msel; m_addr = f_start(msel); m_ls = m_addr;
         m_y = 0; m_ln = 0; m_gap = 0;
         tag = c ? "R3" : "R2";
      end else if (l) begin
         tag = c ? "R3" : "R5";
         if (m_y < 511) m_y++;
         if (m_y > 28 && m_y < 284) begin
            if (m_gap > 0) begin
               m_gap--; tag = "R6";
            end else begin
               m_ln++;
               if (m_ln % 8 != 0) begin
                  m_addr = f_wrap(m_ls + 1); m_ls = m_addr;
               end else begin
                  int g;
                  g = 256 / f_rows(m_mode) - 8;
                  m_addr = f_wrap(m_addr - 7); m_ls = m_addr;
                  if (g != 0 && m_ln == f_rows(m_mode) * 8) begin
                     m_gap = 312 - f_rows(m_mode) * (8 + g) + g; tag = "R7";
                  end else begin
                     m_gap = g; tag = "R6";
                  end
               end
            end
         end
      end else if (c) begin
         if (m_gap > 0) tag = "R6";
         else begin
            tag = (m_addr + 8 >= 'h8000) ? "R4" : "R3";
            m_addr = f_wrap(m_addr + 8);
         end
      end else tag = "R3";
      exp_addr_q.push_back(m_addr);
      exp_gap_q.push_back(m_gap != 0);
      exp_tag_q.push_back(tag);
   endtask

   task automatic go_idle();
      @(negedge clk);
      frame_go = 0; line_go = 0; col_go = 0;
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_addr_q.size() > 0) begin
         int    ea;
         bit    eg;
         string t;
         ea = exp_addr_q.pop_front();
         eg = exp_gap_q.pop_front();
         t  = exp_tag_q.pop_front();
         checks++;
         if (int'(scr_addr) != ea || row_gap != eg) begin
            fails++;
            $display("FAIL %s addr=%h gap=%0d expected addr=%h gap=%0d", t, scr_addr, row_gap, ea[15:0], eg);
         end
      end
   end

   task automatic run_frame(int fm, int om, int nlines);
      strobe(1, 0, 0, fm);
      for (int k = 1; k < nlines; k++) begin
         strobe(0, 1, 0, om);
         if (m_y >= 28 && m_y < 284)
            for (int c = 0; c < f_cols(m_mode); c++) strobe(0, 0, 1, om);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (scr_addr !== 16'h6000) begin
         fails++; $display("FAIL R1 addr=%h expected addr=6000", scr_addr);
      end
      checks++;
      if (row_gap !== 1'b0) begin
         fails++; $display("FAIL R1 gap=%0d expected gap=0", row_gap);
      end
      strobe(0, 0, 1, 0);
      run_frame(6, 0, 312);
      run_frame(3, 2, 312);
      run_frame(0, 6, 312);
      run_frame(2, 1, 312);
      strobe(1, 0, 1, 1);
      strobe(0, 1, 1, 1);
      strobe(0, 0, 1, 1);
      strobe(1, 1, 1, 4);
      strobe(1, 0, 0, 2);
      for (int k = 0; k < 28; k++) strobe(0, 1, 0, 2);
      for (int k = 0; k < 660; k++) strobe(0, 0, 1, 2);
      run_frame(7, 0, 60);
      run_frame(5, 7, 40);
      go_idle();
      repeat (4) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1-R7 run actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule